// File: doc/BRIEF.md
# PCM Receive Frame Timebase

This block produces the bit, frame and multiframe timing that a serial PCM receive formatter needs in a channel unit that terminates several line receivers. Each of three line receivers delivers a multiframe sync level. A select input names the one receiver that sets the alignment. A rising sync on that receiver starts a programmable delay, counted in bit periods. The delay stands in for the receive FIFO fill level. When the delay runs out, the bit counter and the frame counter are both forced to zero and a PCM multiframe sync is raised. After that, the counters run freely, using a programmable frame length and a programmable multiframe length.

The bit clock is not a separate clock domain. The block oversamples four candidate clock sources on the system clock: the recovered PLL clock, the external receive clock, the auxiliary external clock and the transmit clock. It turns the chosen edge of the selected source into a one-cycle bit tick. An invert input moves the active edge from rising to falling. Downstream logic reads the bit position, the frame number, the multiframe sync and a frame-start flag, and qualifies them with the bit tick.

Top module: `pcm_rx_timebase`

## Requirements
- R1: After `rst`, `bit_pos` and `frame_num` are 0, `mf_sync` and `bit_tick` are 0, and `frame_start` is 1.
- R2: With `clk_inv`=0, `bit_tick` pulses for one system clock per rising edge of `clk_src[clk_sel]`, two system clocks after the edge is presented. Source codes are: 0 recovered PLL, 1 external receive, 2 auxiliary external, 3 transmit.
- R3: With `clk_inv`=1, `bit_tick` pulses on falling edges of the selected source instead, with the same latency.
- R4: On a bit tick with no alignment load, `bit_pos` increments. When `bit_pos` is at or above `frame_len_m1`, it returns to 0 and the frame counter advances.
- R5: On such a frame advance, `frame_num` returns to 0 when it is at or above `mf_len_m1`. Otherwise it increments.
- R6: `line_sync` is sampled on bit ticks. Only a 0-to-1 change on channel `master_sel` (values 0..2) starts alignment. The other channels, and the value 3, have no effect on the counters.
- R7: A master sync seen on a tick arms a delay of `sync_delay` ticks. When it expires, on that tick `bit_pos` and `frame_num` load 0 and `mf_sync` goes to 1 for exactly that bit period. A delay of 0 loads on the sync tick itself.
- R8: A master sync that arrives while a delay is pending restarts the delay from `sync_delay`. The pending load is discarded.
- R9: `frame_start` is 1 exactly while `bit_pos` is 0.
- R10: `rx_rst` clears both counters and `mf_sync`, and cancels any pending delay, on the next system clock regardless of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the clock sources |
| rst | input | 1 | Synchronous active-high reset |
| rx_rst | input | 1 | Receive timebase reinitialise, synchronous |
| clk_src | input | 4 | Candidate bit clock levels (0 PLL, 1 ext rx, 2 aux, 3 tx) |
| clk_sel | input | 2 | Index of the bit clock source |
| clk_inv | input | 1 | 1 selects the falling edge as active |
| line_sync | input | 3 | Multiframe sync levels from the line receivers |
| master_sel | input | 2 | Master receiver index; 3 selects none |
| sync_delay | input | 10 | Alignment delay in bit periods |
| frame_len_m1 | input | 8 | Bits per frame minus one |
| mf_len_m1 | input | 6 | Frames per multiframe minus one |
| bit_tick | output | 1 | One-cycle strobe per active bit clock edge |
| bit_pos | output | 8 | Current bit within the frame |
| frame_num | output | 6 | Current frame within the multiframe |
| mf_sync | output | 1 | PCM multiframe sync, one bit period long |
| frame_start | output | 1 | High during bit 0 of every frame |

## Verification
A wrong edge-detect state shows at the ports as a `bit_tick` that is missing, doubled or one cycle off. It appears within two system clocks of the source edge. A corrupted delay count or a stale sync history moves the `mf_sync` pulse and the zeroing of `bit_pos`/`frame_num` to the wrong bit period. This is visible on the tick where the load was due, at most `sync_delay` bit periods after the master sync. A bad counter state breaks the wrap pattern or the `frame_start` flag within one frame length. The bench compares every output on every system clock, so each of these faults is caught at its first visible cycle.

// File: rtl/rxtb_pkg.sv
package rxtb_pkg;
  typedef enum logic [1:0] {
    SRC_PLL = 2'd0,
    SRC_EXT = 2'd1,
    SRC_AUX = 2'd2,
    SRC_TX  = 2'd3
  } clk_src_e;
  localparam int NUM_SRC  = 4;
  localparam int NUM_LINE = 3;
endpackage

// File: rtl/rxtb_clk_pick.sv
module rxtb_clk_pick #(
  parameter int NSRC = 4,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [SW-1:0]   sel,
  input  logic            inv,
  output logic            tick
);
  logic [NSRC-1:0] src_q, src_q2;
  logic now_lvl, old_lvl, edge_c;

  always_comb begin
    now_lvl = src_q[sel];
    old_lvl = src_q2[sel];
    edge_c  = inv ? (old_lvl & ~now_lvl) : (~old_lvl & now_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      src_q2 <= '0;
      tick   <= 1'b0;
    end else begin
      src_q  <= src;
      src_q2 <= src_q;
      tick   <= edge_c;
    end
  end

  // R2 / R3: one selected edge gives one strobe, never two in a row
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    tick && $stable(sel) && $stable(inv) |=> !tick)
    else $error("a_r2_single_strobe");
endmodule

// File: rtl/rxtb_sync_delay.sv
module rxtb_sync_delay #(
  parameter int NLINE = 3,
  parameter int DLY_W = 10,
  localparam int MSW = $clog2(NLINE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_rst,
  input  logic             tick,
  input  logic [NLINE-1:0] line_sync,
  input  logic [MSW-1:0]   master_sel,
  input  logic [DLY_W-1:0] delay,
  output logic             load
);
  logic [NLINE-1:0] sprev, rise;
  logic             m_rise, busy;
  logic [DLY_W-1:0] cnt;

  always_comb begin
    rise   = line_sync & ~sprev;
    m_rise = 1'b0;
    for (int i = 0; i < NLINE; i++)
      if (master_sel == MSW'(i)) m_rise = rise[i];
    load = tick && !rx_rst &&
           ((m_rise && delay == '0) ||
            (!m_rise && busy && cnt == DLY_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || rx_rst) begin
      sprev <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (tick) begin
      sprev <= line_sync;
      if (m_rise) begin
        cnt  <= delay;
        busy <= (delay != '0);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == DLY_W'(1)) busy <= 1'b0;
      end
    end
  end

  // R8: a master sync restarts the delay from the programmed value
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    tick && m_rise && !rx_rst && delay != '0 |=> busy && cnt == $past(delay))
    else $error("a_r8_restart");
  // R6: the delay state moves only on bit ticks
  a_r6_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick && !rx_rst |=> $stable(cnt) && $stable(busy))
    else $error("a_r6_tick_only");
  // R7: a pending delay always has a count left
  a_r7_pending_nonzero: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt != '0)
    else $error("a_r7_pending_nonzero");
endmodule

// File: rtl/rxtb_counters.sv
module rxtb_counters #(
  parameter int FLEN_W = 8,
  parameter int MF_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_rst,
  input  logic              tick,
  input  logic              load,
  input  logic [FLEN_W-1:0] flen_m1,
  input  logic [MF_W-1:0]   mflen_m1,
  output logic [FLEN_W-1:0] bitc,
  output logic [MF_W-1:0]   frm,
  output logic              mf,
  output logic              fs
);
  always_ff @(posedge clk) begin
    if (rst || rx_rst) begin
      bitc <= '0;
      frm  <= '0;
      mf   <= 1'b0;
      fs   <= 1'b1;
    end else if (tick) begin
      if (load) begin
        bitc <= '0;
        frm  <= '0;
        mf   <= 1'b1;
        fs   <= 1'b1;
      end else begin
        mf <= 1'b0;
        if (bitc >= flen_m1) begin
          bitc <= '0;
          fs   <= 1'b1;
          frm  <= (frm >= mflen_m1) ? '0 : frm + 1'b1;
        end else begin
          bitc <= bitc + 1'b1;
          fs   <= 1'b0;
        end
      end
    end
  end

  a_r4_bit_wrap: assert property (@(posedge clk) disable iff (rst)
    tick && !load && !rx_rst && bitc >= flen_m1 |=> bitc == '0)
    else $error("a_r4_bit_wrap");
  a_r5_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    tick && !load && !rx_rst && bitc >= flen_m1 && frm >= mflen_m1 |=> frm == '0)
    else $error("a_r5_frame_wrap");
  a_r7_align: assert property (@(posedge clk) disable iff (rst)
    tick && load && !rx_rst |=> mf && bitc == '0 && frm == '0)
    else $error("a_r7_align");
  a_r9_start_flag: assert property (@(posedge clk) disable iff (rst)
    fs == (bitc == '0))
    else $error("a_r9_start_flag");
  a_r10_reinit: assert property (@(posedge clk) disable iff (rst)
    rx_rst |=> bitc == '0 && frm == '0 && !mf)
    else $error("a_r10_reinit");
endmodule

// File: rtl/pcm_rx_timebase.sv
module pcm_rx_timebase
  import rxtb_pkg::*;
#(
  parameter int FLEN_W = 8,
  parameter int MF_W   = 6,
  parameter int DLY_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_rst,
  input  logic [3:0]        clk_src,
  input  logic [1:0]        clk_sel,
  input  logic              clk_inv,
  input  logic [2:0]        line_sync,
  input  logic [1:0]        master_sel,
  input  logic [DLY_W-1:0]  sync_delay,
  input  logic [FLEN_W-1:0] frame_len_m1,
  input  logic [MF_W-1:0]   mf_len_m1,
  output logic              bit_tick,
  output logic [FLEN_W-1:0] bit_pos,
  output logic [MF_W-1:0]   frame_num,
  output logic              mf_sync,
  output logic              frame_start
);
  logic load;

  rxtb_clk_pick #(.NSRC(NUM_SRC)) u_pick (
    .clk(clk), .rst(rst), .src(clk_src), .sel(clk_sel),
    .inv(clk_inv), .tick(bit_tick)
  );

  rxtb_sync_delay #(.NLINE(NUM_LINE), .DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .rx_rst(rx_rst), .tick(bit_tick),
    .line_sync(line_sync), .master_sel(master_sel),
    .delay(sync_delay), .load(load)
  );

  rxtb_counters #(.FLEN_W(FLEN_W), .MF_W(MF_W)) u_cnt (
    .clk(clk), .rst(rst), .rx_rst(rx_rst), .tick(bit_tick), .load(load),
    .flen_m1(frame_len_m1), .mflen_m1(mf_len_m1),
    .bitc(bit_pos), .frm(frame_num), .mf(mf_sync), .fs(frame_start)
  );
endmodule

// File: tb/pcm_rx_timebase_test.sv
`timescale 1ns/1ps
module pcm_rx_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_rst = 1'b0;
  logic [3:0]  clk_src = '0;
  logic [1:0]  clk_sel = '0;
  logic        clk_inv = 1'b0;
  logic [2:0]  line_sync = '0;
  logic [1:0]  master_sel = '0;
  logic [9:0]  sync_delay = '0;
  logic [7:0]  frame_len_m1 = 8'd7;
  logic [5:0]  mf_len_m1 = 6'd3;
  logic        bit_tick, mf_sync, frame_start;
  logic [7:0]  bit_pos;
  logic [5:0]  frame_num;

  always #2 clk = ~clk;

  pcm_rx_timebase uut (
    .clk(clk), .rst(rst), .rx_rst(rx_rst), .clk_src(clk_src),
    .clk_sel(clk_sel), .clk_inv(clk_inv), .line_sync(line_sync),
    .master_sel(master_sel), .sync_delay(sync_delay),
    .frame_len_m1(frame_len_m1), .mf_len_m1(mf_len_m1),
    .bit_tick(bit_tick), .bit_pos(bit_pos), .frame_num(frame_num),
    .mf_sync(mf_sync), .frame_start(frame_start)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit sel_edge(input bit old_l, input bit new_l, input bit inv);
    return inv ? (old_l && !new_l) : (!old_l && new_l);
  endfunction

  function automatic int wrap_next(input int v, input int lim);
    return (v >= lim) ? 0 : v + 1;
  endfunction

  // reference model state
  int    eb = 0, ef = 0, ecnt = 0;
  bit    emf = 0, ebusy = 0, restarted = 0;
  bit [2:0] esprev = '0;
  bit [3:0] src_prev = '0;
  bit    tp0 = 0, tp1 = 0;
  string ctag = "R1";
  bit    armed = 0;
  int    cyc = 0;

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      if (armed) begin
        chk(bit_pos == eb, ctag, bit_pos, eb);
        chk(frame_num == ef, ctag, frame_num, ef);
        chk(mf_sync == emf, (ctag == "R8") ? "R8" : "R7", mf_sync, emf);
        chk(frame_start == (eb == 0), "R9", frame_start, eb == 0);
        chk(bit_tick == tp1, clk_inv ? "R3" : "R2", bit_tick, tp1);
      end
      if (rst) begin
        armed = 1;
        eb = 0; ef = 0; emf = 0; ebusy = 0; ecnt = 0; esprev = '0;
        tp0 = 0; tp1 = 0; src_prev = '0; ctag = "R1"; restarted = 0;
      end else begin
        if (rx_rst) begin
          eb = 0; ef = 0; emf = 0; ebusy = 0; ecnt = 0; esprev = '0;
          ctag = "R10"; restarted = 0;
        end else if (bit_tick) begin
          bit [2:0] rise;
          bit mrise, ld, other;
          rise  = line_sync & ~esprev;
          mrise = (master_sel < 2'd3) ? rise[master_sel] : 1'b0;
          other = (rise != 3'b000) && !mrise;
          ld = (mrise && sync_delay == 0) || (!mrise && ebusy && ecnt == 1);
          esprev = line_sync;
          if (mrise) begin
            if (ebusy) restarted = 1; else restarted = 0;
            ecnt = sync_delay; ebusy = (sync_delay != 0);
          end else if (ebusy) begin
            ecnt = ecnt - 1;
            if (ecnt == 0) ebusy = 0;
          end
          if (ld) begin
            eb = 0; ef = 0; emf = 1;
            ctag = restarted ? "R8" : "R7";
          end else begin
            emf = 0;
            if (eb >= frame_len_m1) begin
              eb = 0; ef = wrap_next(ef, mf_len_m1);
              ctag = other ? "R6" : "R5";
            end else begin
              eb = eb + 1;
              ctag = other ? "R6" : "R4";
            end
          end
        end
        tp1 = tp0;
        tp0 = sel_edge(src_prev[clk_sel], clk_src[clk_sel], clk_inv);
        src_prev = clk_src;
      end
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // stimulus
  int div [4] = '{0, 0, 0, 0};
  int sync_t = 50;
  bit sync_on = 0;

  task automatic step();
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) begin
      div[i]++;
      if (div[i] >= i + 2) begin div[i] = 0; clk_src[i] = ~clk_src[i]; end
    end
    if (sync_t == 0) begin
      if (sync_on) begin
        line_sync = '0; sync_on = 0; sync_t = $urandom_range(30, 300);
      end else begin
        line_sync = 3'b001 << $urandom_range(0, 2);
        if ($urandom_range(0, 5) == 0) line_sync = line_sync | 3'b010;
        sync_on = 1; sync_t = $urandom_range(10, 40);
      end
    end else sync_t--;
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(bit_pos == 0 && frame_num == 0 && !mf_sync && frame_start && !bit_tick,
        "R1", {bit_pos, frame_num}, 0);
    for (int ph = 0; ph < 5; ph++) begin
      clk_sel = 2'(ph % 4);
      clk_inv = ph[0];
      case (ph)
        0: begin frame_len_m1 = 8'd7;  mf_len_m1 = 6'd3; sync_delay = 10'd0;  end
        1: begin frame_len_m1 = 8'd23; mf_len_m1 = 6'd5; sync_delay = 10'd3;  end
        2: begin frame_len_m1 = 8'd4;  mf_len_m1 = 6'd0; sync_delay = 10'd12; end
        3: begin frame_len_m1 = 8'd0;  mf_len_m1 = 6'd2; sync_delay = 10'd1;  end
        default: begin frame_len_m1 = 8'd9; mf_len_m1 = 6'd7; sync_delay = 10'd20; end
      endcase
      for (int k = 0; k < 12000; k++) begin
        step();
        if (k % 2500 == 0) master_sel = 2'($urandom_range(0, 3));
        if (k == 7000) rx_rst = 1'b1;   // R10 directed
        if (k == 7001) rx_rst = 1'b0;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule